// File: doc/BRIEF.md
# Clock Manager Power Sequencer

This block steps an on-chip clock manager through its power phases. It starts in an off phase. When power is requested, it passes through a wake-up phase and then an acquisition phase, and then it settles in a steady phase. When the request goes away, it passes through a timed shutdown phase and returns to off. The wake-up, acquisition and shutdown phases each last a programmable number of clock cycles. These timers stand in for the analog settling and shutdown behaviour of the clock manager.

A power request exists only when the enable bit is set and configuration allows the clock manager to run. Configuration allows it to run in two cases: the run-during-configuration bit is set, or the configuration-complete input is high. The block drives three outputs, all registered: an analog power enable, a flag that says the output clock is usable, and a 3-bit status code naming the current phase.

Top module: `clkmgr_pwr_seq`

## Requirements
- R1: While reset is high, the block holds status 0 (off), with the power enable and the clock-valid flag both low.
- R2: A power request is enable AND (run-during-configuration OR configuration-complete). When a request is seen in the off phase, the next cycle shows status 1 (wake-up) with the power enable high.
- R3: When run-during-configuration and configuration-complete are both 0, the block stays in off with power disabled, whatever the enable bit is.
- R4: With the request held, the wake-up phase lasts max(W,1) cycles, where W is the wake-up count input, and is then followed by status 2 (acquisition).
- R5: With the request held, the acquisition phase lasts max(A,1) cycles, where A is the acquisition count input, and is then followed by status 3 (steady).
- R6: The clock-valid flag is high in the steady phase and in no other phase.
- R7: When the request is lost in wake-up, acquisition or steady, the next cycle shows status 4 (shutdown) with clock-valid low.
- R8: The shutdown phase lasts max(S,1) cycles, where S is the shutdown count input, whatever the request does. It is then followed by off. The power enable is high in every phase except off.
- R9: A request that is present when shutdown ends leads to exactly one off cycle, and then to wake-up.
- R10: Status encoding: off=0, wake-up=1, acquisition=2, steady=3, shutdown=4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Power enable bit |
| cfg_done_i | input | 1 | Configuration complete |
| run_in_cfg_i | input | 1 | Allow operation before configuration completes |
| wake_cycles_i | input | CNT_W | Wake-up phase length in cycles (0 treated as 1) |
| acq_cycles_i | input | CNT_W | Acquisition phase length in cycles (0 treated as 1) |
| shut_cycles_i | input | CNT_W | Shutdown phase length in cycles (0 treated as 1) |
| pwr_en_o | output | 1 | Analog power enable |
| clk_valid_o | output | 1 | Output clock is usable |
| status_o | output | 3 | Current phase code |

## Verification
The assertions check the following on every cycle. The clock-valid flag never appears outside steady. The power enable follows the phase. The block never leaves off without a request. A lost request always leads to shutdown. Shutdown is never cut short. The phase timer never wraps. The exact phase lengths, the zero-count boundary, re-enabling during shutdown, and losing the request when configuration-complete drops can only be shown by the bench's scenarios. Those scenarios are compared on every cycle against a behavioural model.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [2:0] {
    CSQ_OFF    = 3'd0,
    CSQ_WAKE   = 3'd1,
    CSQ_ACQ    = 3'd2,
    CSQ_STEADY = 3'd3,
    CSQ_SHUT   = 3'd4
  } csq_state_e;
endpackage

// File: rtl/csq_gate.sv
module csq_gate (
  input  logic enable_i,
  input  logic cfg_done_i,
  input  logic run_in_cfg_i,
  output logic req_o
);
  // Power is requested only when configuration rules permit operation
  assign req_o = enable_i & (run_in_cfg_i | cfg_done_i);
endmodule

// File: rtl/csq_timer.sv
module csq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] next_elapsed;

  assign next_elapsed = {1'b0, cnt_q} + SUM_W'(1);
  assign last         = next_elapsed >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (!last) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R4/R5/R8: the phase counter never wraps while a phase is running
  assert_cnt_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !last) |=> (cnt_q != '0));
endmodule

// File: rtl/csq_fsm.sv
module csq_fsm
  import csq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             last,
  input  logic [CNT_W-1:0] wake_cycles,
  input  logic [CNT_W-1:0] acq_cycles,
  input  logic [CNT_W-1:0] shut_cycles,
  output logic [CNT_W-1:0] limit,
  output logic             clr,
  output logic [2:0]       state_o,
  output logic             pwr_o,
  output logic             valid_o
);
  csq_state_e state_q, state_d;
  logic       pwr_q, valid_q;

  always_comb begin
    unique case (state_q)
      CSQ_WAKE: limit = wake_cycles;
      CSQ_ACQ:  limit = acq_cycles;
      CSQ_SHUT: limit = shut_cycles;
      default:  limit = '0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CSQ_OFF:    if (req) state_d = CSQ_WAKE;
      CSQ_WAKE:   if (!req) state_d = CSQ_SHUT; else if (last) state_d = CSQ_ACQ;
      CSQ_ACQ:    if (!req) state_d = CSQ_SHUT; else if (last) state_d = CSQ_STEADY;
      CSQ_STEADY: if (!req) state_d = CSQ_SHUT;
      CSQ_SHUT:   if (last) state_d = CSQ_OFF;
      default:    state_d = CSQ_OFF;
    endcase
  end

  assign clr = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CSQ_OFF;
      pwr_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pwr_q   <= (state_d != CSQ_OFF);
      valid_q <= (state_d == CSQ_STEADY);
    end
  end

  assign state_o = state_q;
  assign pwr_o   = pwr_q;
  assign valid_o = valid_q;

  assert_valid_steady_R6: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (state_q == CSQ_STEADY));
  assert_off_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == CSQ_OFF && !req) |=> (state_q == CSQ_OFF));
  assert_drop_to_shut_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {CSQ_WAKE, CSQ_ACQ, CSQ_STEADY} && !req) |=> (state_q == CSQ_SHUT));
  assert_shut_not_cut_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == CSQ_SHUT && !last) |=> (state_q == CSQ_SHUT));
  assert_pwr_phase_R8: assert property (@(posedge clk) disable iff (rst)
    pwr_q == (state_q != CSQ_OFF));
  assert_code_legal_R10: assert property (@(posedge clk) disable iff (rst)
    state_q inside {CSQ_OFF, CSQ_WAKE, CSQ_ACQ, CSQ_STEADY, CSQ_SHUT});
endmodule

// File: rtl/clkmgr_pwr_seq.sv
module clkmgr_pwr_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable_i,
  input  logic             cfg_done_i,
  input  logic             run_in_cfg_i,
  input  logic [CNT_W-1:0] wake_cycles_i,
  input  logic [CNT_W-1:0] acq_cycles_i,
  input  logic [CNT_W-1:0] shut_cycles_i,
  output logic             pwr_en_o,
  output logic             clk_valid_o,
  output logic [2:0]       status_o
);
  logic             req;
  logic             last;
  logic             clr;
  logic [CNT_W-1:0] limit;

  csq_gate u_gate (
    .enable_i    (enable_i),
    .cfg_done_i  (cfg_done_i),
    .run_in_cfg_i(run_in_cfg_i),
    .req_o       (req)
  );

  csq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .limit(limit),
    .last (last)
  );

  csq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .last       (last),
    .wake_cycles(wake_cycles_i),
    .acq_cycles (acq_cycles_i),
    .shut_cycles(shut_cycles_i),
    .limit      (limit),
    .clr        (clr),
    .state_o    (status_o),
    .pwr_o      (pwr_en_o),
    .valid_o    (clk_valid_o)
  );

  // R3: without configuration permission the block never leaves off
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (status_o == 3'd0 && !run_in_cfg_i && !cfg_done_i) |=> (status_o == 3'd0));
endmodule

// File: tb/clkmgr_pwr_seq_test.sv
`timescale 1ns/1ps
module clkmgr_pwr_seq_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_i = 1'b0, cfg_done_i = 1'b0, run_in_cfg_i = 1'b0;
  logic [CNT_W-1:0] wake_cycles_i = 8'd3, acq_cycles_i = 8'd4, shut_cycles_i = 8'd2;
  logic pwr_en_o, clk_valid_o;
  logic [2:0] status_o;

  int checks = 0;
  int failures = 0;
  int ms = 0;
  int mel = 0;

  always #2.5 clk = ~clk;

  clkmgr_pwr_seq #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .enable_i(enable_i), .cfg_done_i(cfg_done_i),
    .run_in_cfg_i(run_in_cfg_i), .wake_cycles_i(wake_cycles_i),
    .acq_cycles_i(acq_cycles_i), .shut_cycles_i(shut_cycles_i),
    .pwr_en_o(pwr_en_o), .clk_valid_o(clk_valid_o), .status_o(status_o)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lim(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // Behavioural reference: phase number and cycles already spent in it
  always @(posedge clk) begin
    automatic bit req = enable_i && (run_in_cfg_i || cfg_done_i);
    if (rst) begin
      ms = 0; mel = 0;
    end else begin
      case (ms)
        0: if (req) begin ms = 1; mel = 0; end
        1: if (!req) begin ms = 4; mel = 0; end
           else if (mel + 1 >= lim(int'(wake_cycles_i))) begin ms = 2; mel = 0; end
           else mel++;
        2: if (!req) begin ms = 4; mel = 0; end
           else if (mel + 1 >= lim(int'(acq_cycles_i))) begin ms = 3; mel = 0; end
           else mel++;
        3: if (!req) begin ms = 4; mel = 0; end
        default: if (mel + 1 >= lim(int'(shut_cycles_i))) begin ms = 0; mel = 0; end
                 else mel++;
      endcase
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(status_o), ms, "R10 status vs model");
      chk(int'(pwr_en_o), (ms != 0) ? 1 : 0, "R8 power enable vs model");
      chk(int'(clk_valid_o), (ms == 3) ? 1 : 0, "R6 clock valid vs model");
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    lf = 8'h5a;
    step(1);
    // R1
    chk(int'(status_o), 0, "R1 reset status");
    chk(int'(pwr_en_o), 0, "R1 reset power");
    chk(int'(clk_valid_o), 0, "R1 reset valid");
    step(2);
    rst = 1'b0;
    enable_i = 1'b1;
    step(5);
    chk(int'(status_o), 0, "R3 held off before configuration");
    chk(int'(pwr_en_o), 0, "R3 power stays off");
    cfg_done_i = 1'b1;
    step(1);
    chk(int'(status_o), 1, "R2 wake after request");
    chk(int'(pwr_en_o), 1, "R2 power on in wake");
    step(2);
    chk(int'(status_o), 1, "R4 still waking");
    step(1);
    chk(int'(status_o), 2, "R4 wake ends after W cycles");
    step(3);
    chk(int'(status_o), 2, "R5 still acquiring");
    step(1);
    chk(int'(status_o), 3, "R5 steady after A cycles");
    chk(int'(clk_valid_o), 1, "R6 valid in steady");
    enable_i = 1'b0;
    step(1);
    chk(int'(status_o), 4, "R7 shutdown on disable");
    chk(int'(clk_valid_o), 0, "R7 valid drops");
    enable_i = 1'b1;
    step(1);
    chk(int'(status_o), 4, "R8 shutdown not aborted by re-enable");
    chk(int'(pwr_en_o), 1, "R8 power held in shutdown");
    step(1);
    chk(int'(status_o), 0, "R9 one off cycle after shutdown");
    chk(int'(pwr_en_o), 0, "R8 power off in off");
    step(1);
    chk(int'(status_o), 1, "R9 restart wake");
    cfg_done_i = 1'b0;
    step(1);
    chk(int'(status_o), 4, "R7 configuration loss in wake");
    run_in_cfg_i = 1'b1;
    step(2);
    chk(int'(status_o), 0, "R8 shutdown length");
    step(1);
    chk(int'(status_o), 1, "R2 run-during-configuration allows power");
    enable_i = 1'b0;
    step(6);
    chk(int'(status_o), 0, "R8 back to off");
    wake_cycles_i = '0; acq_cycles_i = '0; shut_cycles_i = '0;
    enable_i = 1'b1;
    step(1);
    chk(int'(status_o), 1, "R4 zero count wake");
    step(1);
    chk(int'(status_o), 2, "R4 zero count wake is one cycle");
    step(1);
    chk(int'(status_o), 3, "R5 zero count acquisition is one cycle");
    enable_i = 1'b0;
    step(1);
    chk(int'(status_o), 4, "R7 drop from steady");
    step(1);
    chk(int'(status_o), 0, "R8 zero count shutdown is one cycle");
    wake_cycles_i = 8'd2; acq_cycles_i = 8'd3; shut_cycles_i = 8'd3;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      enable_i     = lf[0] | lf[1] | lf[2];
      cfg_done_i   = lf[3] | lf[4];
      run_in_cfg_i = lf[5] & lf[6];
      step(1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule